// File: doc/BRIEF.md
# SMBus Host Register and Status Unit

This block is the byte-wide register front end of an SMBus host controller. Software reaches it through a small offset space using single-cycle writes and combinational reads. It holds the transaction setup: control, command, slave address, two data bytes, a block data byte, a PEC byte and an auxiliary control byte. It also keeps a status register in which sticky event flags sit beside a live busy bit.

A control write with the start bit set, made while the unit is idle, launches a transaction toward a bus-side engine over a start/done/error handshake. While the transaction runs, the setup registers are frozen. A control write with the kill bit set aborts the transaction and reports it as failed. When the engine finishes, the outcome is recorded in the status flags. A successful read also returns the engine's two data bytes into the data registers.

The sequencer has three states:
- `SQ_IDLE`: not busy.
- `SQ_ISSUE`: busy, with the one-cycle engine start asserted.
- `SQ_WAIT`: busy, waiting for the engine's done.

The transitions are:
- launch: `SQ_IDLE` to `SQ_ISSUE`, on a control write with the start bit.
- issued: `SQ_ISSUE` to `SQ_WAIT`, after one cycle.
- finish: `SQ_WAIT` to `SQ_IDLE`, on engine done.
- abort: `SQ_ISSUE` or `SQ_WAIT` to `SQ_IDLE`, on a control write with the kill bit.

Top module: `smbus_host_regs`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), every register reads 0x00, and the engine outputs, `crc_en` and `blkbuf_en` are 0.
- R2: The defined offsets are:
  - 0: status
  - 2: control
  - 3: command
  - 4: slave address
  - 5: data0
  - 6: data1
  - 7: block data
  - 8: PEC
  - 12: auxiliary status, which always reads 0x00
  - 13: auxiliary control

  Reads of any other offset return 0x00, and writes to other offsets change nothing.
- R3: A write to control (offset 2) with bit 6 set, made while idle, sets busy (status bit 0) at the next edge. It also asserts `eng_start` for exactly one cycle. While the transaction runs, `eng_kind` shows control bits [4:2] and `eng_pec` shows control bit 7.
- R4: In the wait state, `eng_done` with `eng_err`=00 clears busy and sets the complete flag (status bit 1) at the same edge.
- R5: `eng_done` with a nonzero `eng_err` ends the transaction without setting the complete flag. The error codes map to status flags as follows:
  - `eng_err`=01 (no acknowledge) sets device error, status bit 2.
  - `eng_err`=10 (lost arbitration) sets bus error, status bit 3.
  - `eng_err`=11 sets failed, status bit 4.
- R6: Status bits 7, 4, 3, 2 and 1 are cleared by writing 1 to them, and writing 0 leaves them unchanged. A flag set in the same cycle as its clear stays set.
- R7: A control write with bit 1 set while busy does three things:
  - It pulses `eng_abort` in that cycle.
  - It clears busy and sets failed (bit 4) at the next edge.
  - It overrides an `eng_done` that arrives in the same cycle.
- R8: While busy, writes to control, command, slave address, data0 and data1 are ignored, except for the kill action.
- R9: On a successful finish, if slave address bit 0 is 1 (read), data0 and data1 are loaded from `eng_rd0` and `eng_rd1`.
- R10: Auxiliary control (offset 13) keeps only bits [1:0]. Bit 0 drives `crc_en` and bit 1 drives `blkbuf_en`.
- R11: An `eng_byte` pulse while busy sets the byte-done flag, status bit 7.
- R12: Control reads back bits 7 and [4:2] as written. The start bit (6) and the kill bit (1) always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle |
| reg_addr | input | 4 | Register offset for reads and writes |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data of `reg_addr` |
| eng_start | output | 1 | One-cycle transaction launch to the engine |
| eng_abort | output | 1 | One-cycle abort to the engine |
| eng_kind | output | 3 | Transaction type, control bits [4:2] |
| eng_pec | output | 1 | PEC append requested, control bit 7 |
| eng_addr | output | 8 | Slave address byte with read/write bit in bit 0 |
| eng_cmd | output | 8 | Command byte |
| eng_d0 | output | 8 | Data0 byte |
| eng_d1 | output | 8 | Data1 byte |
| crc_en | output | 1 | Hardware PEC enable, auxiliary control bit 0 |
| blkbuf_en | output | 1 | Block buffer enable, auxiliary control bit 1 |
| eng_done | input | 1 | Engine finished the transaction |
| eng_err | input | 2 | Outcome with done: 00 ok, 01 nack, 10 lost arbitration, 11 failed |
| eng_byte | input | 1 | Engine moved one block byte |
| eng_rd0 | input | 8 | First byte read from the slave |
| eng_rd1 | input | 8 | Second byte read from the slave |

## Verification
Register writes, status flag changes and busy changes all appear at the first clock edge after the stimulus cycle. `eng_start` is high for the cycle after the launching write. `eng_abort` and read data are combinational in the stimulus cycle itself.

The bench drives inputs on the falling edge. It runs a behavioural model on each rising edge and compares all outputs 5 ns after that edge, before the next inputs change. Directed reads present an offset on the falling edge and sample 5 ns later, still ahead of the next rising edge.

// File: rtl/smbh_pkg.sv
package smbh_pkg;
    localparam int REG_W = 8;
    localparam int OFS_W = 4;
    localparam int KIND_W = 3;
    localparam int ERR_W = 2;

    localparam logic [OFS_W-1:0] OFS_STAT = 4'd0;
    localparam logic [OFS_W-1:0] OFS_CTRL = 4'd2;
    localparam logic [OFS_W-1:0] OFS_CMD  = 4'd3;
    localparam logic [OFS_W-1:0] OFS_SADR = 4'd4;
    localparam logic [OFS_W-1:0] OFS_D0   = 4'd5;
    localparam logic [OFS_W-1:0] OFS_D1   = 4'd6;
    localparam logic [OFS_W-1:0] OFS_BLK  = 4'd7;
    localparam logic [OFS_W-1:0] OFS_PEC  = 4'd8;
    localparam logic [OFS_W-1:0] OFS_AXS  = 4'd12;
    localparam logic [OFS_W-1:0] OFS_AXC  = 4'd13;

    // status bit positions
    localparam int SB_BUSY = 0;
    localparam int SB_INTR = 1;
    localparam int SB_DEV  = 2;
    localparam int SB_BUS  = 3;
    localparam int SB_FAIL = 4;
    localparam int SB_BYTE = 7;
    localparam logic [REG_W-1:0] STICKY_MASK = 8'h9E;

    // control bit positions
    localparam int CB_KILL  = 1;
    localparam int CB_KLO   = 2;
    localparam int CB_START = 6;
    localparam int CB_PEC   = 7;
    localparam logic [REG_W-1:0] CTRL_KEEP = 8'h9C;
    localparam logic [REG_W-1:0] AUX_KEEP  = 8'h03;

    localparam logic [ERR_W-1:0] ERR_NONE = 2'b00;
    localparam logic [ERR_W-1:0] ERR_NACK = 2'b01;
    localparam logic [ERR_W-1:0] ERR_LOST = 2'b10;
    localparam logic [ERR_W-1:0] ERR_FAIL = 2'b11;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_ISSUE = 2'd1,
        SQ_WAIT  = 2'd2
    } sq_state_t;
endpackage

// File: rtl/smbh_seq.sv
module smbh_seq
    import smbh_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_req,
    input  logic             kill_req,
    input  logic             eng_done,
    input  logic [ERR_W-1:0] eng_err,
    output logic             busy,
    output logic             eng_start,
    output logic             eng_abort,
    output logic             ev_ok,
    output logic             ev_nack,
    output logic             ev_lost,
    output logic             ev_fail,
    output logic             ev_kill
);
    sq_state_t st_q, st_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= SQ_IDLE;
        else        st_q <= st_nx;
    end

    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            SQ_IDLE:  if (go_req) st_nx = SQ_ISSUE;
            SQ_ISSUE: st_nx = kill_req ? SQ_IDLE : SQ_WAIT;
            SQ_WAIT:  if (kill_req || eng_done) st_nx = SQ_IDLE;
            default:  st_nx = SQ_IDLE;
        endcase
    end

    always_comb begin
        busy      = 1'b0;
        eng_start = 1'b0;
        ev_ok     = 1'b0;
        ev_nack   = 1'b0;
        ev_lost   = 1'b0;
        ev_fail   = 1'b0;
        unique case (st_q)
            SQ_IDLE: ;
            SQ_ISSUE: begin
                busy      = 1'b1;
                eng_start = 1'b1;
            end
            SQ_WAIT: begin
                busy = 1'b1;
                if (eng_done && !kill_req) begin
                    ev_ok   = (eng_err == ERR_NONE);
                    ev_nack = (eng_err == ERR_NACK);
                    ev_lost = (eng_err == ERR_LOST);
                    ev_fail = (eng_err == ERR_FAIL);
                end
            end
            default: ;
        endcase
        ev_kill   = busy && kill_req;
        eng_abort = ev_kill;
    end

    // R3
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start);

    // R5
    ev_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ev_ok, ev_nack, ev_lost, ev_fail, ev_kill}));
endmodule

// File: rtl/smbh_status.sv
module smbh_status #(
    parameter int          W    = 8,
    parameter logic [W-1:0] MASK = 8'h9E
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_ev,
    input  logic [W-1:0] clr_ev,
    output logic [W-1:0] flags
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (MASK[i]) begin : g_sticky
            logic f_q;
            always_ff @(posedge clk) begin
                if (!rst_n)         f_q <= 1'b0;
                else if (set_ev[i]) f_q <= 1'b1;
                else if (clr_ev[i]) f_q <= 1'b0;
            end
            assign flags[i] = f_q;

            // R6
            w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_ev[i] && !set_ev[i]) |=> !flags[i]);
        end else begin : g_none
            assign flags[i] = 1'b0;
        end
    end
endmodule

// File: rtl/smbh_rdmux.sv
module smbh_rdmux
    import smbh_pkg::*;
(
    input  logic [OFS_W-1:0] addr,
    input  logic [REG_W-1:0] stat,
    input  logic [REG_W-1:0] ctrl,
    input  logic [REG_W-1:0] cmd,
    input  logic [REG_W-1:0] sadr,
    input  logic [REG_W-1:0] d0,
    input  logic [REG_W-1:0] d1,
    input  logic [REG_W-1:0] blk,
    input  logic [REG_W-1:0] pec,
    input  logic [REG_W-1:0] aux,
    output logic [REG_W-1:0] rdata
);
    always_comb begin
        rdata = '0;
        case (addr)
            OFS_STAT: rdata = stat;
            OFS_CTRL: rdata = ctrl;
            OFS_CMD:  rdata = cmd;
            OFS_SADR: rdata = sadr;
            OFS_D0:   rdata = d0;
            OFS_D1:   rdata = d1;
            OFS_BLK:  rdata = blk;
            OFS_PEC:  rdata = pec;
            OFS_AXS:  rdata = '0;
            OFS_AXC:  rdata = aux;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/smbus_host_regs.sv
module smbus_host_regs
    import smbh_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [3:0]       reg_addr,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    output logic             eng_start,
    output logic             eng_abort,
    output logic [2:0]       eng_kind,
    output logic             eng_pec,
    output logic [7:0]       eng_addr,
    output logic [7:0]       eng_cmd,
    output logic [7:0]       eng_d0,
    output logic [7:0]       eng_d1,
    output logic             crc_en,
    output logic             blkbuf_en,
    input  logic             eng_done,
    input  logic [1:0]       eng_err,
    input  logic             eng_byte,
    input  logic [7:0]       eng_rd0,
    input  logic [7:0]       eng_rd1
);
    logic [REG_W-1:0] ctrl_q, cmd_q, sadr_q, d0_q, d1_q, blk_q, pec_q, aux_q;
    logic [REG_W-1:0] stat_q, flags, set_ev, clr_ev;
    logic busy, ev_ok, ev_nack, ev_lost, ev_fail, ev_kill;
    logic wr_stat, wr_ctrl, wr_cmd, wr_sadr, wr_d0, wr_d1, wr_blk, wr_pec, wr_axc;
    logic go_req, kill_req;

    assign wr_stat = reg_wr && (reg_addr == OFS_STAT);
    assign wr_ctrl = reg_wr && (reg_addr == OFS_CTRL);
    assign wr_cmd  = reg_wr && (reg_addr == OFS_CMD);
    assign wr_sadr = reg_wr && (reg_addr == OFS_SADR);
    assign wr_d0   = reg_wr && (reg_addr == OFS_D0);
    assign wr_d1   = reg_wr && (reg_addr == OFS_D1);
    assign wr_blk  = reg_wr && (reg_addr == OFS_BLK);
    assign wr_pec  = reg_wr && (reg_addr == OFS_PEC);
    assign wr_axc  = reg_wr && (reg_addr == OFS_AXC);

    assign go_req   = wr_ctrl && reg_wdata[CB_START];
    assign kill_req = wr_ctrl && reg_wdata[CB_KILL];

    smbh_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .go_req    (go_req),
        .kill_req  (kill_req),
        .eng_done  (eng_done),
        .eng_err   (eng_err),
        .busy      (busy),
        .eng_start (eng_start),
        .eng_abort (eng_abort),
        .ev_ok     (ev_ok),
        .ev_nack   (ev_nack),
        .ev_lost   (ev_lost),
        .ev_fail   (ev_fail),
        .ev_kill   (ev_kill)
    );

    always_comb begin
        set_ev          = '0;
        set_ev[SB_BYTE] = eng_byte && busy;
        set_ev[SB_FAIL] = ev_fail || ev_kill;
        set_ev[SB_BUS]  = ev_lost;
        set_ev[SB_DEV]  = ev_nack;
        set_ev[SB_INTR] = ev_ok;
        clr_ev          = wr_stat ? (reg_wdata & STICKY_MASK) : '0;
    end

    smbh_status #(.W(REG_W), .MASK(STICKY_MASK)) u_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_ev (set_ev),
        .clr_ev (clr_ev),
        .flags  (flags)
    );

    always_comb begin
        stat_q          = flags;
        stat_q[SB_BUSY] = busy;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            cmd_q  <= '0;
            sadr_q <= '0;
            d0_q   <= '0;
            d1_q   <= '0;
            blk_q  <= '0;
            pec_q  <= '0;
            aux_q  <= '0;
        end else begin
            if (!busy) begin
                if (wr_ctrl) ctrl_q <= reg_wdata & CTRL_KEEP;
                if (wr_cmd)  cmd_q  <= reg_wdata;
                if (wr_sadr) sadr_q <= reg_wdata;
                if (wr_d0)   d0_q   <= reg_wdata;
                if (wr_d1)   d1_q   <= reg_wdata;
            end else if (ev_ok && sadr_q[0]) begin
                d0_q <= eng_rd0;
                d1_q <= eng_rd1;
            end
            if (wr_blk) blk_q <= reg_wdata;
            if (wr_pec) pec_q <= reg_wdata;
            if (wr_axc) aux_q <= reg_wdata & AUX_KEEP;
        end
    end

    smbh_rdmux u_rd (
        .addr  (reg_addr),
        .stat  (stat_q),
        .ctrl  (ctrl_q),
        .cmd   (cmd_q),
        .sadr  (sadr_q),
        .d0    (d0_q),
        .d1    (d1_q),
        .blk   (blk_q),
        .pec   (pec_q),
        .aux   (aux_q),
        .rdata (reg_rdata)
    );

    assign eng_kind  = ctrl_q[CB_KLO +: KIND_W];
    assign eng_pec   = ctrl_q[CB_PEC];
    assign eng_addr  = sadr_q;
    assign eng_cmd   = cmd_q;
    assign eng_d0    = d0_q;
    assign eng_d1    = d1_q;
    assign crc_en    = aux_q[0];
    assign blkbuf_en = aux_q[1];

    // R7
    kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kill_req && busy) |=> (!busy && flags[SB_FAIL]));

    // R4
    ok_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !eng_start && eng_done && eng_err == ERR_NONE && !kill_req)
        |=> (!busy && flags[SB_INTR]));

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(cmd_q) && $stable(sadr_q)));

    // R9
    rdload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_ok && sadr_q[0]) |=> (d0_q == $past(eng_rd0) && d1_q == $past(eng_rd1)));
endmodule

// File: tb/sim_smbus_host_regs.sv
module sim_smbus_host_regs;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [3:0] reg_addr = 4'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       eng_start, eng_abort, eng_pec, crc_en, blkbuf_en;
    logic [2:0] eng_kind;
    logic [7:0] eng_addr, eng_cmd, eng_d0, eng_d1;
    logic       eng_done = 1'b0;
    logic [1:0] eng_err = 2'b00;
    logic       eng_byte = 1'b0;
    logic [7:0] eng_rd0 = 8'd0;
    logic [7:0] eng_rd1 = 8'd0;

    int checks = 0;
    int fails = 0;
    bit ended = 1'b0;
    bit cmp_on = 1'b0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    smbus_host_regs u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_start(eng_start),
        .eng_abort(eng_abort), .eng_kind(eng_kind), .eng_pec(eng_pec),
        .eng_addr(eng_addr), .eng_cmd(eng_cmd), .eng_d0(eng_d0), .eng_d1(eng_d1),
        .crc_en(crc_en), .blkbuf_en(blkbuf_en), .eng_done(eng_done),
        .eng_err(eng_err), .eng_byte(eng_byte), .eng_rd0(eng_rd0), .eng_rd1(eng_rd1)
    );

    // behavioural reference model
    int   m_ph = 0;   // 0 idle, 1 issuing, 2 waiting
    logic [7:0] m_fl = 0, m_ctrl = 0, m_cmd = 0, m_sa = 0, m_d0 = 0, m_d1 = 0;
    logic [7:0] m_blk = 0, m_pec = 0, m_aux = 0;

    function automatic logic [7:0] m_read(input logic [3:0] a);
        case (a)
            4'd0:  return m_fl | ((m_ph != 0) ? 8'h01 : 8'h00);
            4'd2:  return m_ctrl;
            4'd3:  return m_cmd;
            4'd4:  return m_sa;
            4'd5:  return m_d0;
            4'd6:  return m_d1;
            4'd7:  return m_blk;
            4'd8:  return m_pec;
            4'd13: return m_aux;
            default: return 8'h00;
        endcase
    endfunction

    always @(posedge clk) begin
        logic bsy, kill, go, fin;
        logic [52:0] exp_v, act_v;
        if (!rst_n) begin
            m_ph = 0; m_fl = 0; m_ctrl = 0; m_cmd = 0; m_sa = 0;
            m_d0 = 0; m_d1 = 0; m_blk = 0; m_pec = 0; m_aux = 0;
        end else begin
            bsy  = (m_ph != 0);
            kill = reg_wr && reg_addr == 4'd2 && reg_wdata[1] && bsy;
            go   = reg_wr && reg_addr == 4'd2 && reg_wdata[6] && !bsy;
            fin  = (m_ph == 2) && eng_done && !kill;
            if (reg_wr && reg_addr == 4'd0) m_fl = m_fl & ~(reg_wdata & 8'h9E);
            if (eng_byte && bsy) m_fl = m_fl | 8'h80;
            if (kill) m_fl = m_fl | 8'h10;
            if (fin) begin
                case (eng_err)
                    2'd0: m_fl = m_fl | 8'h02;
                    2'd1: m_fl = m_fl | 8'h04;
                    2'd2: m_fl = m_fl | 8'h08;
                    default: m_fl = m_fl | 8'h10;
                endcase
                if (eng_err == 2'd0 && m_sa[0]) begin
                    m_d0 = eng_rd0;
                    m_d1 = eng_rd1;
                end
            end
            if (reg_wr && !bsy) begin
                case (reg_addr)
                    4'd2: m_ctrl = reg_wdata & 8'h9C;
                    4'd3: m_cmd = reg_wdata;
                    4'd4: m_sa = reg_wdata;
                    4'd5: m_d0 = reg_wdata;
                    4'd6: m_d1 = reg_wdata;
                    default: ;
                endcase
            end
            if (reg_wr && reg_addr == 4'd7)  m_blk = reg_wdata;
            if (reg_wr && reg_addr == 4'd8)  m_pec = reg_wdata;
            if (reg_wr && reg_addr == 4'd13) m_aux = reg_wdata & 8'h03;
            if (kill) m_ph = 0;
            else if (m_ph == 0 && go) m_ph = 1;
            else if (m_ph == 1) m_ph = 2;
            else if (fin) m_ph = 0;
        end
        cmp_on = 1'b1;
        #5;
        exp_v = {m_read(reg_addr), (m_ph == 1),
                 (reg_wr && reg_addr == 4'd2 && reg_wdata[1] && m_ph != 0),
                 m_ctrl[4:2], m_ctrl[7], m_sa, m_cmd, m_d0, m_d1, m_aux[0], m_aux[1]};
        act_v = {reg_rdata, eng_start, eng_abort, eng_kind, eng_pec, eng_addr,
                 eng_cmd, eng_d0, eng_d1, crc_en, blkbuf_en};
        if (!ended) begin
            checks++;
            if (act_v !== exp_v) begin
                fails++;
                $display("FAIL %s per-cycle compare t=%0t actual=%h expected=%h",
                         cur_req, $time, act_v, exp_v);
            end
        end
    end

    task automatic cyc(input logic w, input logic [3:0] a, input logic [7:0] d,
                       input logic dn, input logic [1:0] er, input logic by);
        @(negedge clk);
        reg_wr = w; reg_addr = a; reg_wdata = d;
        eng_done = dn; eng_err = er; eng_byte = by;
        @(negedge clk);
        reg_wr = 1'b0; eng_done = 1'b0; eng_err = 2'b00; eng_byte = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        cyc(1'b1, a, d, 1'b0, 2'b00, 1'b0);
    endtask

    task automatic idle();
        cyc(1'b0, 4'd0, 8'h00, 1'b0, 2'b00, 1'b0);
    endtask

    // call right after a task that returned on a falling edge
    task automatic rd_expect(input logic [3:0] a, input logic [7:0] e, input string tag);
        reg_addr = a;
        #5;
        checks++;
        if (reg_rdata !== e) begin
            fails++;
            $display("FAIL %s read offset %0d actual=%h expected=%h", tag, a, reg_rdata, e);
        end
    endtask

    task automatic finish_run();
        ended = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values
        cur_req = "R1";
        idle();
        for (int a = 0; a < 16; a++) rd_expect(4'(a), 8'h00, "R1");
        // R2 undefined offsets
        cur_req = "R2";
        wr(4'd1, 8'h55); wr(4'd9, 8'h66); wr(4'd15, 8'h77); wr(4'd12, 8'h99);
        rd_expect(4'd1, 8'h00, "R2");
        rd_expect(4'd15, 8'h00, "R2");
        rd_expect(4'd12, 8'h00, "R2");
        rd_expect(4'd0, 8'h00, "R2");
        wr(4'd7, 8'h3B); wr(4'd8, 8'hC7);
        rd_expect(4'd7, 8'h3B, "R2");
        rd_expect(4'd8, 8'hC7, "R2");
        // R3 launch, R8 freeze, R4 finish, R12 readback
        cur_req = "R3";
        wr(4'd3, 8'hA5); wr(4'd4, 8'h5A); wr(4'd5, 8'h11); wr(4'd6, 8'h22);
        wr(4'd2, 8'hCA);
        rd_expect(4'd0, 8'h01, "R3");
        rd_expect(4'd2, 8'h88, "R12");
        cur_req = "R8";
        wr(4'd3, 8'hFF); wr(4'd4, 8'hFF); wr(4'd2, 8'h84);
        rd_expect(4'd3, 8'hA5, "R8");
        rd_expect(4'd4, 8'h5A, "R8");
        rd_expect(4'd2, 8'h88, "R8");
        cur_req = "R4";
        cyc(1'b0, 4'd0, 8'h00, 1'b1, 2'b00, 1'b0);
        rd_expect(4'd0, 8'h02, "R4");
        rd_expect(4'd5, 8'h11, "R4");
        // R6 write-one-to-clear
        cur_req = "R6";
        wr(4'd0, 8'h00);
        rd_expect(4'd0, 8'h02, "R6");
        wr(4'd0, 8'h02);
        rd_expect(4'd0, 8'h00, "R6");
        // R5 error outcomes
        cur_req = "R5";
        for (int e = 1; e < 4; e++) begin
            wr(4'd2, 8'h48);
            idle();
            cyc(1'b0, 4'd0, 8'h00, 1'b1, 2'(e), 1'b0);
            rd_expect(4'd0, 8'h02 << e, "R5");
            wr(4'd0, 8'hFF);
            rd_expect(4'd0, 8'h00, "R5");
        end
        // R7 kill in wait state, in issue state, and against a same-cycle done
        cur_req = "R7";
        wr(4'd2, 8'h4C);
        idle(); idle();
        wr(4'd2, 8'h02);
        rd_expect(4'd0, 8'h10, "R7");
        wr(4'd0, 8'h10);
        wr(4'd2, 8'h4C);
        wr(4'd2, 8'h02);
        rd_expect(4'd0, 8'h10, "R7");
        wr(4'd0, 8'h10);
        wr(4'd2, 8'h4C);
        idle();
        cyc(1'b1, 4'd2, 8'h02, 1'b1, 2'b00, 1'b0);
        rd_expect(4'd0, 8'h10, "R7");
        wr(4'd2, 8'h02);
        rd_expect(4'd0, 8'h10, "R7");
        wr(4'd0, 8'h10);
        // R9 read loads data
        cur_req = "R9";
        wr(4'd4, 8'hA1);
        wr(4'd2, 8'h4C);
        idle();
        eng_rd0 = 8'h3C; eng_rd1 = 8'hC3;
        cyc(1'b0, 4'd0, 8'h00, 1'b1, 2'b00, 1'b0);
        rd_expect(4'd5, 8'h3C, "R9");
        rd_expect(4'd6, 8'hC3, "R9");
        wr(4'd0, 8'h02);
        // R11 byte event
        cur_req = "R11";
        eng_byte = 1'b1;
        idle();
        rd_expect(4'd0, 8'h00, "R11");
        wr(4'd2, 8'h54);
        cyc(1'b0, 4'd0, 8'h00, 1'b0, 2'b00, 1'b1);
        rd_expect(4'd0, 8'h81, "R11");
        cyc(1'b0, 4'd0, 8'h00, 1'b1, 2'b00, 1'b0);
        rd_expect(4'd0, 8'h82, "R11");
        // R6 set beats clear in the same cycle
        cur_req = "R6";
        wr(4'd0, 8'h80);
        rd_expect(4'd0, 8'h02, "R6");
        wr(4'd2, 8'h40);
        idle();
        cyc(1'b1, 4'd0, 8'h02, 1'b1, 2'b00, 1'b0);
        rd_expect(4'd0, 8'h02, "R6");
        // R10 auxiliary control
        cur_req = "R10";
        wr(4'd13, 8'hFF);
        rd_expect(4'd13, 8'h03, "R10");
        checks++;
        if ({crc_en, blkbuf_en} !== 2'b11) begin
            fails++;
            $display("FAIL R10 aux outputs actual=%b expected=11", {crc_en, blkbuf_en});
        end
        wr(4'd13, 8'h02);
        rd_expect(4'd13, 8'h02, "R10");
        // R12 start and kill bits never read back
        cur_req = "R12";
        wr(4'd2, 8'h02);
        rd_expect(4'd2, 8'h00, "R12");
        rd_expect(4'd0, 8'h02, "R12");
        idle();
        finish_run();
    end
endmodule